// File: doc/BRIEF.md
# Single-Precision to Unsigned Integer Converter

This unit takes one IEEE-754 binary32 value and turns it into an unsigned integer that is either 32 or 64 bits wide. The operand is captured when `in_valid` is high. One clock later, the unit presents the integer on `result`, together with two flags: `flag_inv` (the value cannot be represented) and `flag_prec` (fraction bits were dropped).

The rounding mode normally comes from a global two-bit control field. An operation may carry its own rounding field instead. That field is honoured only when its enable is set and the operand is marked as coming from a register.

When the rounded value does not fit the destination, the unit raises invalid. The returned value then depends on the mask bit:
- Mask set: the result is all ones in the chosen width.
- Mask clear: the result is zero, and the surrounding pipeline is expected to take the trap.

The 64-bit width is granted only when both the width select and the 64-bit mode qualifier are high.

Top module: `f2u_convert`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid`, `result`, `flag_inv` and `flag_prec` reflect that operand after that edge. When `in_valid` is low, `out_valid` drops and `result` and the flags hold their values. Reset clears all outputs to zero.
- R2: The destination width is 64 bits only when `wide_sel` and `mode64` are both 1. Otherwise the width is 32, `wide_sel` has no effect, and `result[63:32]` is zero.
- R3: The rounding-control encoding is 2'b00 nearest-even, 2'b01 toward minus infinity, 2'b10 toward plus infinity and 2'b11 toward zero. `op_rc` replaces `glob_rc` only when `op_rc_en` and `src_is_reg` are both 1.
- R4: An inexact value is rounded to an integer in the selected mode. Under nearest-even, a tie goes to the even integer. A value that is already an integer passes through unchanged.
- R5: If the rounded magnitude is 2^w or more, for destination width w, `flag_inv` is raised.
- R6: Any operand with exponent field 8'hFF raises `flag_inv`. This covers infinities, quiet NaNs and signalling NaNs.
- R7: When invalid is raised, `result` is 2^w-1 if `inv_mask` is 1, and zero if `inv_mask` is 0.
- R8: A negative operand is valid only if it rounds to zero. In that case the result is 0. Both +0 and -0 give 0 with no flag.
- R9: `flag_prec` is set when nonzero fraction bits are discarded and the result is valid. It is never set together with `flag_inv`.
- R10: Subnormal operands are tiny nonzero values. They round to 0 or to 1 depending on the rounding mode, and set `flag_prec` when the result is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| operand | input | 32 | Single-precision source value |
| glob_rc | input | 2 | Global rounding control |
| op_rc_en | input | 1 | Per-operation rounding override enable |
| src_is_reg | input | 1 | Operand comes from a register |
| op_rc | input | 2 | Per-operation rounding control |
| wide_sel | input | 1 | Request 64-bit destination |
| mode64 | input | 1 | 64-bit mode active |
| inv_mask | input | 1 | Invalid exception masked |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Unsigned integer result |
| flag_inv | output | 1 | Invalid flag |
| flag_prec | output | 1 | Precision (inexact) flag |

## Verification
Rounding and range checking can act on the same operand. This happens when a negative fraction rounds away from zero: -0.6 under nearest-even, or -0.3 toward minus infinity. The rounding step produces a magnitude of one, and the range check must then turn that into invalid with the precision flag suppressed. The bench feeds such operands next to their mirror cases, where the same fraction rounds to zero under a different mode. It expects precision alone in the mirror case, and invalid alone, with the masked all-ones value, in the failing case.

// File: rtl/f2u_pkg.sv
package f2u_pkg;
  localparam int unsigned EXP_W    = 8;
  localparam int unsigned FRAC_W   = 23;
  localparam int unsigned SIG_W    = FRAC_W + 1;
  localparam int unsigned BIAS     = 127;
  localparam int unsigned WIDE_W   = 64;
  localparam int unsigned NARROW_W = 32;
  localparam int unsigned MAG_W    = WIDE_W + 1;

  typedef enum logic [1:0] {
    RC_NEAR = 2'b00,
    RC_DOWN = 2'b01,
    RC_UP   = 2'b10,
    RC_ZERO = 2'b11
  } rc_e;

  // Decide whether the truncated magnitude must be bumped by one.
  function automatic logic round_inc(input rc_e rc, input logic neg,
                                     input logic lsb, input logic half,
                                     input logic sticky);
    logic inexact;
    inexact = half | sticky;
    case (rc)
      RC_NEAR: round_inc = half & (sticky | lsb);
      RC_DOWN: round_inc = neg & inexact;
      RC_UP:   round_inc = ~neg & inexact;
      default: round_inc = 1'b0;
    endcase
  endfunction

  // Unbiased exponent; subnormals use the minimum normal exponent.
  function automatic logic signed [9:0] unbias(input logic [EXP_W-1:0] e);
    if (e == '0) unbias = -10'sd126;
    else         unbias = $signed({2'b00, e}) - 10'sd127;
  endfunction

  // Does a magnitude fit the destination width?
  function automatic logic fits(input logic [MAG_W-1:0] mag, input logic wide);
    if (wide) fits = ~mag[MAG_W-1];
    else      fits = ~|mag[MAG_W-1:NARROW_W];
  endfunction
endpackage

// File: rtl/f2u_rmode_sel.sv
module f2u_rmode_sel
  import f2u_pkg::*;
(
  input  logic [1:0] glob_rc,
  input  logic       op_rc_en,
  input  logic       src_is_reg,
  input  logic [1:0] op_rc,
  output rc_e        eff_rc,
  output logic       use_op_rc
);
  assign use_op_rc = op_rc_en & src_is_reg;
  assign eff_rc    = use_op_rc ? rc_e'(op_rc) : rc_e'(glob_rc);
endmodule

// File: rtl/f2u_align.sv
module f2u_align
  import f2u_pkg::*;
(
  input  logic [31:0]       operand,
  output logic              neg,
  output logic              special,
  output logic              too_big,
  output logic [WIDE_W-1:0] int_part,
  output logic              half,
  output logic              sticky
);
  localparam int unsigned PAD_W = 2 * SIG_W;

  logic [EXP_W-1:0]  exp_f;
  logic [SIG_W-1:0]  sig;
  logic signed [9:0] ex;
  logic [PAD_W-1:0]  padded;
  logic [5:0]        lsh;
  logic [9:0]        rsh;

  assign neg     = operand[31];
  assign exp_f   = operand[30:23];
  assign sig     = {exp_f != '0, operand[FRAC_W-1:0]};
  assign ex      = unbias(exp_f);
  assign special = (exp_f == '1);
  assign too_big = ~special & (ex >= 10'sd64);
  assign lsh     = 6'(ex - 10'sd23);
  assign rsh     = 10'(10'sd23 - ex);

  always_comb begin
    int_part = '0;
    half     = 1'b0;
    sticky   = 1'b0;
    padded   = '0;
    if (special || too_big) begin
      int_part = '0;
    end else if (ex >= 10'sd23) begin
      int_part = {{(WIDE_W-SIG_W){1'b0}}, sig} << lsh;
    end else if (rsh <= 10'd24) begin
      padded   = {sig, {SIG_W{1'b0}}} >> rsh;
      int_part = {{(WIDE_W-SIG_W){1'b0}}, padded[PAD_W-1:SIG_W]};
      half     = padded[SIG_W-1];
      sticky   = |padded[SIG_W-2:0];
    end else begin
      sticky   = |sig;
    end
  end
endmodule

// File: rtl/f2u_round.sv
module f2u_round
  import f2u_pkg::*;
(
  input  rc_e               rc,
  input  logic              neg,
  input  logic [WIDE_W-1:0] int_part,
  input  logic              half,
  input  logic              sticky,
  output logic [MAG_W-1:0]  mag,
  output logic              inexact,
  output logic              rnd_inc
);
  assign inexact = half | sticky;
  assign rnd_inc = round_inc(rc, neg, int_part[0], half, sticky);
  assign mag     = {1'b0, int_part} + {{(MAG_W-1){1'b0}}, rnd_inc};
endmodule

// File: rtl/f2u_convert.sv
module f2u_convert
  import f2u_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] operand,
  input  logic [1:0]  glob_rc,
  input  logic        op_rc_en,
  input  logic        src_is_reg,
  input  logic [1:0]  op_rc,
  input  logic        wide_sel,
  input  logic        mode64,
  input  logic        inv_mask,
  output logic        out_valid,
  output logic [63:0] result,
  output logic        flag_inv,
  output logic        flag_prec
);
  rc_e               eff_rc;
  logic              use_op_rc;
  logic              neg, special, too_big, half, sticky;
  logic [WIDE_W-1:0] int_part;
  logic [MAG_W-1:0]  mag;
  logic              inexact, rnd_inc;
  logic              wide_eff;
  logic              ev_range_err, ev_neg_err, ev_invalid, ev_prec;
  logic [WIDE_W-1:0] sat_val, next_res;

  f2u_rmode_sel u_rsel (
    .glob_rc(glob_rc), .op_rc_en(op_rc_en), .src_is_reg(src_is_reg),
    .op_rc(op_rc), .eff_rc(eff_rc), .use_op_rc(use_op_rc)
  );

  f2u_align u_align (
    .operand(operand), .neg(neg), .special(special), .too_big(too_big),
    .int_part(int_part), .half(half), .sticky(sticky)
  );

  f2u_round u_round (
    .rc(eff_rc), .neg(neg), .int_part(int_part), .half(half),
    .sticky(sticky), .mag(mag), .inexact(inexact), .rnd_inc(rnd_inc)
  );

  assign wide_eff     = wide_sel & mode64;
  assign ev_range_err = too_big | ~fits(mag, wide_eff);
  assign ev_neg_err   = neg & (mag != '0);
  assign ev_invalid   = special | ev_range_err | ev_neg_err;
  assign ev_prec      = ~ev_invalid & inexact;
  assign sat_val      = wide_eff ? {WIDE_W{1'b1}}
                                 : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
  assign next_res     = ev_invalid ? (inv_mask ? sat_val : '0) : mag[WIDE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_inv  <= 1'b0;
      flag_prec <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= next_res;
        flag_inv  <= ev_invalid;
        flag_prec <= ev_prec;
      end
    end
  end
endmodule

// File: rtl/f2u_convert_chk.sv
module f2u_convert_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] operand,
  input logic        wide_sel,
  input logic        mode64,
  input logic        inv_mask,
  input logic        use_op_rc,
  input logic        op_rc_en,
  input logic        src_is_reg,
  input logic        out_valid,
  input logic [63:0] result,
  input logic        flag_inv,
  input logic        flag_prec
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(flag_inv)); // R1
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode64) |=> result[63:32] == 32'h0); // R2
  AST_OVR_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    use_op_rc |-> (op_rc_en && src_is_reg)); // R3
  AST_SPECIAL_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && operand[30:23] == 8'hFF) |=> flag_inv); // R6
  AST_MASK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && inv_mask && operand[30:23] == 8'hFF) |=> result[31:0] == 32'hFFFF_FFFF); // R7
  AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && operand[30:0] == 31'h0) |=> result == 64'h0 && !flag_inv && !flag_prec); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_inv && flag_prec)); // R9
  AST_WIDE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wide_sel && !mode64) |=> result[63:32] == 32'h0); // R2
endmodule

bind f2u_convert f2u_convert_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
  .wide_sel(wide_sel), .mode64(mode64), .inv_mask(inv_mask),
  .use_op_rc(use_op_rc), .op_rc_en(op_rc_en), .src_is_reg(src_is_reg),
  .out_valid(out_valid), .result(result), .flag_inv(flag_inv),
  .flag_prec(flag_prec)
);

// File: tb/test_f2u_convert.sv
module test_f2u_convert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  glob_rc = 2'b00;
  logic        op_rc_en = 1'b0;
  logic        src_is_reg = 1'b0;
  logic [1:0]  op_rc = 2'b00;
  logic        wide_sel = 1'b0;
  logic        mode64 = 1'b0;
  logic        inv_mask = 1'b1;
  logic        out_valid;
  logic [63:0] result;
  logic        flag_inv, flag_prec;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  f2u_convert i_f2u_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .glob_rc(glob_rc), .op_rc_en(op_rc_en), .src_is_reg(src_is_reg),
    .op_rc(op_rc), .wide_sel(wide_sel), .mode64(mode64),
    .inv_mask(inv_mask), .out_valid(out_valid), .result(result),
    .flag_inv(flag_inv), .flag_prec(flag_prec)
  );

  typedef struct packed {
    logic [31:0] op;
    logic [1:0]  grc;
    logic        oen;
    logic        sreg;
    logic [1:0]  orc;
    logic        wide;
    logic        m64;
    logic        mask;
    logic [63:0] res;
    logic        inv;
    logic        prc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 32;
  // rc: 00 nearest-even, 01 down, 10 up, 11 zero
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd1,          1'b0, 1'b0, 8'd4},  // R4 1.0
    '{32'h40200000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd2,          1'b0, 1'b1, 8'd4},  // R4 2.5 tie even
    '{32'h40600000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd4,          1'b0, 1'b1, 8'd4},  // R4 3.5 tie even
    '{32'h40300000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd3,          1'b0, 1'b1, 8'd4},  // R4 2.75
    '{32'h40200000, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd3,          1'b0, 1'b1, 8'd3},  // R3 2.5 up
    '{32'h40200000, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd2,          1'b0, 1'b1, 8'd3},  // R3 2.5 down
    '{32'h40600000, 2'b11, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd3,          1'b0, 1'b1, 8'd3},  // R3 3.5 zero
    '{32'h3FC00000, 2'b11, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 64'd2,          1'b0, 1'b1, 8'd3},  // R3 override up
    '{32'h3FC00000, 2'b11, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 64'd1,          1'b0, 1'b1, 8'd3},  // R3 memory: global
    '{32'h3FC00000, 2'b11, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b1, 64'd1,          1'b0, 1'b1, 8'd3},  // R3 enable low
    '{32'h3F000000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd0,          1'b0, 1'b1, 8'd4},  // R4 0.5 -> 0
    '{32'h4B000001, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd8388609,    1'b0, 1'b0, 8'd4},  // R4 exact
    '{32'h4E800000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'h40000000,   1'b0, 1'b0, 8'd4},  // R4 2^30
    '{32'hBE99999A, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd0,          1'b0, 1'b1, 8'd8},  // R8 -0.3
    '{32'hBF19999A, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'hFFFFFFFF,   1'b1, 1'b0, 8'd8},  // R8 -0.6 invalid
    '{32'hBF19999A, 2'b11, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd0,          1'b0, 1'b1, 8'd8},  // R8 -0.6 zero
    '{32'hBE99999A, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'hFFFFFFFF,   1'b1, 1'b0, 8'd9},  // R9 -0.3 down
    '{32'h80000000, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd0,          1'b0, 1'b0, 8'd8},  // R8 -0
    '{32'h00000000, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd0,          1'b0, 1'b0, 8'd8},  // R8 +0
    '{32'hBF800000, 2'b11, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd8}, // R8 -1.0
    '{32'h4F7FFFFF, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'hFFFFFF00,   1'b0, 1'b0, 8'd5},  // R5 top 32
    '{32'h4F800000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'hFFFFFFFF,   1'b1, 1'b0, 8'd5},  // R5 2^32 narrow
    '{32'h4F800000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 64'h100000000,  1'b0, 1'b0, 8'd2},  // R2 2^32 wide
    '{32'h4F800000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 64'hFFFFFFFF,   1'b1, 1'b0, 8'd2},  // R2 wide ignored
    '{32'h5F7FFFFF, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 64'hFFFFFF0000000000, 1'b0, 1'b0, 8'd5}, // R5 top 64
    '{32'h5F800000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd7}, // R7 2^64
    '{32'h7F800000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 64'd0,          1'b1, 1'b0, 8'd7},  // R7 unmasked inf
    '{32'h7FC00000, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'hFFFFFFFF,   1'b1, 1'b0, 8'd6},  // R6 qNaN
    '{32'h7F800001, 2'b00, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 8'd6}, // R6 sNaN
    '{32'h00000001, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd1,          1'b0, 1'b1, 8'd10}, // R10 up
    '{32'h00000001, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'd0,          1'b0, 1'b1, 8'd10}, // R10 nearest
    '{32'h80000001, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 64'hFFFFFFFF,   1'b1, 1'b0, 8'd10}  // R10 neg down
  };

  task automatic check(input string tag, input logic [63:0] got_r, input logic [63:0] exp_r,
                       input logic got_i, input logic exp_i,
                       input logic got_p, input logic exp_p);
    checks++;
    if (got_r !== exp_r || got_i !== exp_i || got_p !== exp_p) begin
      failures++;
      $display("FAIL %s: result=%h inv=%b prec=%b expected result=%h inv=%b prec=%b",
               tag, got_r, got_i, got_p, exp_r, exp_i, exp_p);
    end
  endtask

  task automatic drive(input vec_t v);
    operand    = v.op;
    glob_rc    = v.grc;
    op_rc_en   = v.oen;
    src_is_reg = v.sreg;
    op_rc      = v.orc;
    wide_sel   = v.wide;
    mode64     = v.m64;
    inv_mask   = v.mask;
    in_valid   = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset", result, 64'h0, flag_inv, 1'b0, flag_prec, 1'b0);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset out_valid=%b expected 0", out_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vector %0d", VECS[i].req, i), result, VECS[i].res,
            flag_inv, VECS[i].inv, flag_prec, VECS[i].prc);
    end

    // R1 hold: new operand without in_valid must not change outputs
    operand = 32'h40600000;
    glob_rc = 2'b00;
    @(negedge clk);
    check("R1 hold", result, VECS[NV-1].res, flag_inv, 1'b1, flag_prec, 1'b0);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 out_valid idle=%b expected 0", out_valid);
    end

    // R1 back-to-back operands, one result per cycle
    drive(VECS[0]);
    @(negedge clk);
    check("R1 back-to-back first", result, 64'd1, flag_inv, 1'b0, flag_prec, 1'b0);
    drive(VECS[2]);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 back-to-back second", result, 64'd4, flag_inv, 1'b0, flag_prec, 1'b1);
    checks++;
    if (out_valid !== 1'b1) begin
      failures++;
      $display("FAIL R1 out_valid busy=%b expected 1", out_valid);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule